// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block gathers a set of independent interrupt lines from peripherals and stores each unmasked line that goes high as a pending request. Every line is given a level through a writable priority map. The block picks the single pending, unmasked request with the highest level. It raises an interrupt toward the processor only when that level is at or above a programmable floor.

The processor answers with an acknowledge. While the acknowledge is high, the block puts the winner's level, binary encoded, on a small data bus. That level is the vector. The winner is captured in the first acknowledge cycle and held for the whole read. When the acknowledge drops, the delivered request is retired.

The mask, the floor and the per-line levels are written through a plain single-cycle write port. A status output flags a priority map in which two lines share a level. There is no data stream here: the acknowledge is the only handshake, and the block never stalls the processor.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset there are no stored requests, the mask is clear, line i sits at level i, the floor is 0, the interrupt output is low, the data bus is zero and the map-error flag is low.
- R2: A line that is high and unmasked at a clock edge sets its request bit at that edge. The bit stays set after the line returns low.
- R3: A line whose mask bit is 1 at a clock edge is not stored at that edge. A stored request whose mask bit is later set is left out of selection until the mask bit clears again.
- R4: The winner is the stored, unmasked request with the numerically highest level, where a larger level means more urgent.
- R5: The interrupt output is high exactly when a winner exists and its level is greater than or equal to the floor.
- R6: While the acknowledge is high, the data bus carries the captured winner's level, zero-extended. The bus is zero when the acknowledge is low, or when no request qualified in the first acknowledge cycle.
- R7: The winner is captured in the first cycle of the acknowledge. The bus value does not change until the acknowledge falls, even if a higher request arrives in the meantime.
- R8: At the first clock edge where the acknowledge is low after having been high, the request bit of the delivered line is cleared. Clearing takes precedence over a new set of that same bit at that edge. Other pending requests are then served.
- R9: Write address 0 loads the mask (bit i masks line i). Address 1 loads the floor from the low level bits. Address 2+i loads the level of line i from the low level bits. Writes to any other address change nothing.
- R10: The map-error flag is high whenever the levels of the lines are not all distinct. When two lines share a level and both are pending, the lower-numbered line wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | N_LINES | Interrupt lines, one per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration write address |
| cfg_wdata_i | input | N_LINES | Configuration write data |
| iack_i | input | 1 | Interrupt acknowledge from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| dbus_o | output | DATA_W | Vector output bus |
| map_err_o | output | 1 | Priority map has a repeated level |

## Verification
The hardest case to reach is a more urgent request that arrives while an acknowledge is already in progress. It must leave the vector on the bus unchanged. The delivered line must still be retired at the fall, and the late request must win the next acknowledge. The stimulus holds the acknowledge for several cycles and pulses a higher line partway through, then acknowledges again. A second hard case is a tie in the map. The stimulus rewrites one line's level onto another's, raises both lines, and checks which request survives the first retirement.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
  typedef enum logic [1:0] {
    RK_MASK,
    RK_FLOOR,
    RK_LEVEL,
    RK_NONE
  } reg_kind_e;
endpackage

// File: rtl/vic_cfg.sv
`timescale 1ns/1ps
module vic_cfg #(
  parameter int N  = 8,
  parameter int LW = 3,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [N-1:0]    wdata_i,
  output logic [N-1:0]    mask_o,
  output logic [LW-1:0]   floor_o,
  output logic [N*LW-1:0] levels_o,
  output logic            err_o
);
  import vic_pkg::*;
  localparam int LEVELS = 1 << LW;

  reg_kind_e kind;
  always_comb begin
    if (addr_i == AW'(0))                   kind = RK_MASK;
    else if (addr_i == AW'(1))              kind = RK_FLOOR;
    else if (int'(addr_i) < N + 2)          kind = RK_LEVEL;
    else                                    kind = RK_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o  <= '0;
      floor_o <= '0;
    end else if (we_i) begin
      if (kind == RK_MASK)  mask_o  <= wdata_i;
      if (kind == RK_FLOOR) floor_o <= wdata_i[LW-1:0];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_level
    always_ff @(posedge clk) begin
      if (!rst_n)
        levels_o[g*LW +: LW] <= LW'(g);
      else if (we_i && kind == RK_LEVEL && addr_i == AW'(g + 2))
        levels_o[g*LW +: LW] <= wdata_i[LW-1:0];
    end
  end

  logic [LEVELS-1:0] used;
  always_comb begin
    used = '0;
    for (int i = 0; i < N; i++) used[levels_o[i*LW +: LW]] = 1'b1;
    err_o = ~&used[N-1:0];
  end

  assert_floor_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == AW'(1)) |=> floor_o == $past(wdata_i[LW-1:0]));
endmodule

// File: rtl/vic_req.sv
`timescale 1ns/1ps
module vic_req #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_i,
  input  logic [N-1:0]  mask_i,
  input  logic          clr_en_i,
  input  logic [IW-1:0] clr_idx_i,
  output logic [N-1:0]  req_o
);
  logic [N-1:0] req_d;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (clr_en_i && clr_idx_i == IW'(i)) req_d[i] = 1'b0;
      else                                 req_d[i] = req_o[i] | (irq_i[i] & ~mask_i[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_o <= '0;
    else        req_o <= req_d;
  end

  assert_masked_not_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((req_o & ~$past(req_o) & $past(mask_i)) == '0));

  assert_retire_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_i |=> !req_o[$past(clr_idx_i)]);
endmodule

// File: rtl/vic_arb.sv
`timescale 1ns/1ps
module vic_arb #(
  parameter int N  = 8,
  parameter int LW = 3,
  parameter int IW = 3
) (
  input  logic [N-1:0]    req_i,
  input  logic [N-1:0]    mask_i,
  input  logic [N*LW-1:0] levels_i,
  input  logic [LW-1:0]   floor_i,
  output logic            pass_o,
  output logic [LW-1:0]   lvl_o,
  output logic [IW-1:0]   idx_o
);
  logic [N-1:0] cand;
  logic         found;
  always_comb begin
    cand  = req_i & ~mask_i;
    found = 1'b0;
    lvl_o = '0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || levels_i[i*LW +: LW] > lvl_o)) begin
        found = 1'b1;
        lvl_o = levels_i[i*LW +: LW];
        idx_o = IW'(i);
      end
    end
    pass_o = found && (lvl_o >= floor_i);
  end
endmodule

// File: rtl/vic_ack.sv
`timescale 1ns/1ps
module vic_ack #(
  parameter int LW = 3,
  parameter int IW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iack_i,
  input  logic          live_pass_i,
  input  logic [LW-1:0] live_lvl_i,
  input  logic [IW-1:0] live_idx_i,
  output logic [DW-1:0] dbus_o,
  output logic          clr_en_o,
  output logic [IW-1:0] clr_idx_o
);
  logic          iack_q;
  logic          held_ok;
  logic [LW-1:0] held_lvl;
  logic [IW-1:0] held_idx;
  logic          rise;
  logic          sel_ok;
  logic [LW-1:0] sel_lvl;

  assign rise = iack_i & ~iack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iack_q   <= 1'b0;
      held_ok  <= 1'b0;
      held_lvl <= '0;
      held_idx <= '0;
    end else begin
      iack_q <= iack_i;
      if (rise) begin
        held_ok  <= live_pass_i;
        held_lvl <= live_lvl_i;
        held_idx <= live_idx_i;
      end
    end
  end

  always_comb begin
    sel_ok  = rise ? live_pass_i : held_ok;
    sel_lvl = rise ? live_lvl_i  : held_lvl;
    dbus_o  = (iack_i && sel_ok) ? DW'(sel_lvl) : '0;
  end

  assign clr_en_o  = iack_q & ~iack_i & held_ok;
  assign clr_idx_o = held_idx;

  assert_vector_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_i && $past(iack_i)) |-> $stable(dbus_o));

  assert_retire_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en_o |-> $past(iack_i));
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl #(
  parameter  int N_LINES = 8,
  parameter  int DATA_W  = 8,
  localparam int LVL_W   = $clog2(N_LINES),
  localparam int CFG_AW  = $clog2(N_LINES + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               cfg_we_i,
  input  logic [CFG_AW-1:0]  cfg_addr_i,
  input  logic [N_LINES-1:0] cfg_wdata_i,
  input  logic               iack_i,
  output logic               int_o,
  output logic [DATA_W-1:0]  dbus_o,
  output logic               map_err_o
);
  logic [N_LINES-1:0]       mask;
  logic [LVL_W-1:0]         floor_lvl;
  logic [N_LINES*LVL_W-1:0] levels;
  logic [N_LINES-1:0]       req;
  logic                     live_pass;
  logic [LVL_W-1:0]         live_lvl;
  logic [LVL_W-1:0]         live_idx;
  logic                     clr_en;
  logic [LVL_W-1:0]         clr_idx;

  vic_cfg #(.N(N_LINES), .LW(LVL_W), .AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .mask_o(mask), .floor_o(floor_lvl),
    .levels_o(levels), .err_o(map_err_o));

  vic_req #(.N(N_LINES), .IW(LVL_W)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .mask_i(mask),
    .clr_en_i(clr_en), .clr_idx_i(clr_idx), .req_o(req));

  vic_arb #(.N(N_LINES), .LW(LVL_W), .IW(LVL_W)) u_arb (
    .req_i(req), .mask_i(mask), .levels_i(levels), .floor_i(floor_lvl),
    .pass_o(live_pass), .lvl_o(live_lvl), .idx_o(live_idx));

  vic_ack #(.LW(LVL_W), .IW(LVL_W), .DW(DATA_W)) u_ack (
    .clk(clk), .rst_n(rst_n), .iack_i(iack_i), .live_pass_i(live_pass),
    .live_lvl_i(live_lvl), .live_idx_i(live_idx), .dbus_o(dbus_o),
    .clr_en_o(clr_en), .clr_idx_o(clr_idx));

  assign int_o = live_pass;

  assert_int_needs_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> (|(req & ~mask)));
endmodule

// File: tb/vec_irq_ctrl_bench.sv
`timescale 1ns/1ps
module vec_irq_ctrl_bench;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int AW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  irq;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [N-1:0]  cfg_wdata;
  logic          iack;
  logic          int_w;
  logic [DW-1:0] dbus_w;
  logic          err_w;

  always #2.5 clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .iack_i(iack),
    .int_o(int_w), .dbus_o(dbus_w), .map_err_o(err_w));

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  bit [N-1:0] m_req, m_mask;
  int m_floor;
  int m_lvl[N];
  bit m_iack_prev;
  bit h_ok;
  int h_lvl, h_idx;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic void live(output bit ok, output int lvl, output int idx);
    bit f = 0;
    lvl = 0; idx = 0;
    for (int i = 0; i < N; i++)
      if (m_req[i] && !m_mask[i] && (!f || m_lvl[i] > lvl)) begin
        f = 1; lvl = m_lvl[i]; idx = i;
      end
    ok = f && (lvl >= m_floor);
  endfunction

  function automatic bit map_bad();
    bit [N-1:0] seen = '0;
    for (int i = 0; i < N; i++) begin
      if (m_lvl[i] >= N || seen[m_lvl[i]]) return 1;
      seen[m_lvl[i]] = 1;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    bit ok; int l, ix; bit fall;
    if (!rst_n) begin
      m_req = '0; m_mask = '0; m_floor = 0; m_iack_prev = 0;
      h_ok = 0; h_lvl = 0; h_idx = 0;
      for (int i = 0; i < N; i++) m_lvl[i] = i;
    end else begin
      live(ok, l, ix);
      fall = m_iack_prev && !iack;
      for (int i = 0; i < N; i++) begin
        if (fall && h_ok && i == h_idx) m_req[i] = 0;
        else if (irq[i] && !m_mask[i]) m_req[i] = 1;
      end
      if (iack && !m_iack_prev) begin h_ok = ok; h_lvl = l; h_idx = ix; end
      if (cfg_we) begin
        if (cfg_addr == 0) m_mask = cfg_wdata;
        else if (cfg_addr == 1) m_floor = int'(cfg_wdata[LW-1:0]);
        else if (int'(cfg_addr) < N + 2) m_lvl[int'(cfg_addr) - 2] = int'(cfg_wdata[LW-1:0]);
      end
      m_iack_prev = iack;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    bit ok, s_ok; int l, ix, s_lvl, exp_bus;
    if (rst_n && !done) begin
      live(ok, l, ix);
      if (iack && !m_iack_prev) begin s_ok = ok; s_lvl = l; end
      else begin s_ok = h_ok; s_lvl = h_lvl; end
      exp_bus = (iack && s_ok) ? s_lvl : 0;
      chk("R5 int_o vs model", int'(int_w), int'(ok));
      chk("R6 dbus_o vs model", int'(dbus_w), exp_bus);
      chk("R10 map_err_o vs model", int'(err_w), int'(map_bad()));
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wr(input int a, input int d);
    cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = N'(d); tick(); cfg_we = 0;
  endtask
  task automatic pulse(input int bits); irq = N'(bits); tick(); irq = '0; endtask
  task automatic retire(); iack = 1; tick(); iack = 0; tick(); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq = '0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0; iack = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset int", int'(int_w), 0);
    chk("R1 reset bus", int'(dbus_w), 0);
    chk("R1 reset err", int'(err_w), 0);

    // R2: latch and hold
    tick();
    pulse(8'h08);
    @(negedge clk); chk("R2 stored line3 raises int", int'(int_w), 1);
    tick();
    iack = 1;
    @(negedge clk); chk("R6 vector of line3", int'(dbus_w), 3);
    tick(); iack = 0; tick();
    @(negedge clk); chk("R8 line3 retired", int'(int_w), 0);

    // R4 / R7 / R8: highest wins, frozen during ack
    tick();
    pulse(8'h22);
    iack = 1;
    @(negedge clk); chk("R4 line5 beats line1", int'(dbus_w), 5);
    tick(); irq = 8'h80; tick(); irq = '0;
    @(negedge clk); chk("R7 vector held despite line7", int'(dbus_w), 5);
    tick(); iack = 0; tick();
    iack = 1;
    @(negedge clk); chk("R8 next winner line7", int'(dbus_w), 7);
    tick(); iack = 0; tick();
    iack = 1;
    @(negedge clk); chk("R8 then line1", int'(dbus_w), 1);
    tick(); iack = 0; tick();
    @(negedge clk); chk("R8 all retired", int'(int_w), 0);

    // R3: masking
    tick();
    wr(0, 8'h04); pulse(8'h04);
    @(negedge clk); chk("R3 masked line not stored", int'(int_w), 0);
    tick(); wr(0, 0);
    @(negedge clk); chk("R3 unmask shows nothing stored", int'(int_w), 0);
    tick(); pulse(8'h40); wr(0, 8'h40);
    @(negedge clk); chk("R3 stored but masked excluded", int'(int_w), 0);
    tick(); wr(0, 0);
    @(negedge clk); chk("R3 unmasked request returns", int'(int_w), 1);
    tick(); retire();

    // R5 / R6: floor
    wr(1, 6); pulse(8'h10);
    @(negedge clk); chk("R5 level4 below floor6", int'(int_w), 0);
    tick(); iack = 1;
    @(negedge clk); chk("R6 bus zero without winner", int'(dbus_w), 0);
    tick(); iack = 0; tick();
    pulse(8'h40);
    @(negedge clk); chk("R5 level6 equals floor", int'(int_w), 1);
    tick(); retire(); wr(1, 4);
    @(negedge clk); chk("R5 line4 passes lowered floor", int'(int_w), 1);
    tick(); retire(); wr(1, 0);

    // R9 / R10: remap and errors
    wr(2, 7);
    @(negedge clk); chk("R10 duplicate level flagged", int'(err_w), 1);
    tick(); wr(9, 0);
    @(negedge clk); chk("R10 permutation clears flag", int'(err_w), 0);
    tick(); pulse(8'h41); iack = 1;
    @(negedge clk); chk("R9 line0 remapped to level7", int'(dbus_w), 7);
    tick(); iack = 0; tick(); retire(); 
    wr(12, 8'hFF); pulse(8'h08); iack = 1;
    @(negedge clk); chk("R9 stray address ignored", int'(dbus_w), 3);
    tick(); iack = 0; tick();
    wr(4, 5); pulse(8'h24); iack = 1;
    @(negedge clk); chk("R10 tie lowest index", int'(dbus_w), 5);
    tick(); iack = 0; tick();
    @(negedge clk); chk("R10 other tied line remains", int'(int_w), 1);
    tick(); retire();
    @(negedge clk); chk("R10 both tied retired", int'(int_w), 0);

    // random traffic against the model
    tick();
    for (int n = 0; n < 600; n++) begin
      irq = N'($urandom_range(0, 255) & $urandom_range(0, 255));
      if ($urandom_range(0, 3) == 0) iack = ~iack;
      cfg_we = ($urandom_range(0, 9) == 0);
      cfg_addr = AW'($urandom_range(0, 15));
      cfg_wdata = N'($urandom_range(0, 255) & $urandom_range(0, 255));
      tick();
    end
    irq = '0; cfg_we = 0; iack = 0;
    tick(); tick();
    @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule